// File: doc/BRIEF.md
# Serial Real-Time-Clock Bus Master

This block is the host side of a narrow serial link to an external clock chip. The link has one shared data line and three active-low strobes: a chip select, a write strobe and a read strobe. Each bit moves in its own framed strobe cycle. The timing of each cycle is derived from a parameterised count of system clocks per microsecond.

A request carries a register address, a write byte and an operation selector. The master first shifts out the address, least significant bit first. It then does one of three things:
- shifts out the write byte, least significant bit first;
- shifts in one byte, placing the first received bit in bit 0;
- ends the frame, when the request is a command.

After reset, and before it accepts any request, the master runs eight dummy single-bit reads. These align the device to the start of a communication cycle. A finished frame is reported by a one-cycle `done` pulse, and the read byte is valid on `rdata` in that cycle.

Top module: `srtc_master`

## Requirements
- R1: While reset is high, all three strobes are high and the data line is not driven. In the first cycle after reset, `busy` is high.
- R2: After reset the master performs exactly 8 read strobes and no write strobes, then drops `busy`.
- R3: Every frame starts with ADDR_W write strobes that carry the address, least significant bit first.
- R4: For op code 0 (write) with a data address, the address is followed by DATA_W write strobes that carry `req_wdata`, least significant bit first.
- R5: For op code 1 (read) with a data address, the address is followed by DATA_W read strobes. The bit sampled on the first of them lands in `rdata` bit 0, and the last lands in the MSB.
- R6: A request is a command when op bit 1 is set (codes 2 and 3), or when the address is at or above CMD_BASE. A command frame has only the address strobes and no data strobes.
- R7: In a write bit, chip select falls one cycle before the write strobe. The write strobe stays low for exactly US_CYC cycles, with the line driven. The write strobe rises before chip select.
- R8: In a read bit, the line is released and the read strobe stays low for exactly 2*US_CYC cycles. The line is sampled US_CYC cycles after the strobe falls.
- R9: Between consecutive bit cycles, chip select stays high for at least US_CYC cycles.
- R10: `done` is high for exactly one cycle after the last bit of a frame, with `busy` low. A request presented while `busy` is high is ignored.
- R11: Whenever the master is idle, all strobes are high and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; taken only while busy is low |
| req_op | input | 2 | 0 write, 1 read, 2 or 3 command |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Resync or frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | DATA_W | Received byte, valid with done |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line input value |

## Verification
The bench builds the master with CLK_HZ set to 10 MHz, which gives a ten-cycle microsecond. With that setting a full read frame takes a few hundred cycles, so strobe widths and gaps can be counted exactly at every bit. CMD_BASE is lowered to 12. This puts addresses 11 and 12 on either side of the command threshold, so both the data frame and the address-only frame are reachable with the write opcode alone.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

    // Operation selector: bit 1 forces a command frame.
    localparam logic [1:0] OPC_WRITE = 2'd0;
    localparam logic [1:0] OPC_READ  = 2'd1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_STB,
        PH_REL,
        PH_GAP
    } phase_e;

    typedef enum logic [2:0] {
        SQ_RESYNC,
        SQ_IDLE,
        SQ_ADDR,
        SQ_WDATA,
        SQ_RDATA
    } seq_e;

    typedef enum logic [1:0] {
        K_CMD,
        K_WR,
        K_RD
    } kind_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/srtc_bit_phy.sv
module srtc_bit_phy
    import srtc_pkg::*;
#(
    parameter int US_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_rd,
    input  logic wbit,
    input  logic sd_i,
    output logic ready,
    output logic bit_done,
    output logic rbit,
    output logic cs_n,
    output logic wr_n,
    output logic rd_n,
    output logic sd_o,
    output logic sd_oe
);
    localparam int CW = $clog2(2 * US_CYC + 1);
    localparam logic [CW-1:0] ONE_US = CW'(US_CYC - 1);
    localparam logic [CW-1:0] TWO_US = CW'(2 * US_CYC - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          rd_q;
    logic [CW-1:0] stb_last;

    assign stb_last = rd_q ? TWO_US : ONE_US;
    assign ready    = (phase == PH_IDLE);
    assign bit_done = (phase == PH_GAP) && (cnt == ONE_US);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            rd_q  <= 1'b0;
            cs_n  <= 1'b1;
            wr_n  <= 1'b1;
            rd_n  <= 1'b1;
            sd_o  <= 1'b0;
            sd_oe <= 1'b0;
            rbit  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        rd_q  <= is_rd;
                        sd_o  <= is_rd ? 1'b0 : wbit;
                        sd_oe <= ~is_rd;
                        cs_n  <= 1'b0;
                        phase <= PH_SEL;
                    end
                end
                PH_SEL: begin
                    wr_n  <= rd_q;
                    rd_n  <= ~rd_q;
                    cnt   <= '0;
                    phase <= PH_STB;
                end
                PH_STB: begin
                    cnt <= cnt + 1'b1;
                    if (rd_q && cnt == ONE_US)
                        rbit <= sd_i;
                    if (cnt == stb_last) begin
                        wr_n  <= 1'b1;
                        rd_n  <= 1'b1;
                        phase <= PH_REL;
                    end
                end
                PH_REL: begin
                    cs_n  <= 1'b1;
                    sd_oe <= 1'b0;
                    cnt   <= '0;
                    phase <= PH_GAP;
                end
                PH_GAP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == ONE_US)
                        phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!wr_n && !rd_n)); // R7
    AST_STB_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (!wr_n || !rd_n) |-> !cs_n); // R7
    AST_CS_LEADS_WR: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> $past(!cs_n)); // R7
    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> sd_oe); // R7
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(!wr_n)) |-> $stable(sd_o)); // R7
    AST_RD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !sd_oe); // R8
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GAP) |-> (cs_n && wr_n && rd_n)); // R9

endmodule

// File: rtl/srtc_seq.sv
module srtc_seq
    import srtc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RESYNC_N = 8,
    parameter int CMD_BASE = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              phy_ready,
    input  logic              phy_bit_done,
    input  logic              phy_rbit,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              phy_start,
    output logic              phy_is_rd,
    output logic              phy_wbit
);
    localparam int SW   = ADDR_W + DATA_W;
    localparam int CMAX = max3(ADDR_W, DATA_W, RESYNC_N);
    localparam int IW   = $clog2(CMAX + 1);

    seq_e              state;
    kind_e             kind;
    logic [IW-1:0]     idx;
    logic [SW-1:0]     sh_w;
    logic [DATA_W-1:0] sh_r;
    logic              done_q;
    logic              accept;
    logic              req_cmd;
    kind_e             req_kind;

    assign req_cmd  = req_op[1] || (req_addr >= ADDR_W'(CMD_BASE));
    assign req_kind = req_cmd ? K_CMD : (req_op[0] ? K_RD : K_WR);
    assign accept   = (state == SQ_IDLE) && req_valid;

    assign busy      = (state != SQ_IDLE);
    assign done      = done_q;
    assign rdata     = sh_r;
    assign phy_start = phy_ready && (state != SQ_IDLE);
    assign phy_is_rd = (state == SQ_RESYNC) || (state == SQ_RDATA);
    assign phy_wbit  = sh_w[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_RESYNC;
            kind   <= K_CMD;
            idx    <= '0;
            sh_w   <= '0;
            sh_r   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                sh_w  <= {req_wdata, req_addr};
                kind  <= req_kind;
                idx   <= '0;
                state <= SQ_ADDR;
            end else if (phy_bit_done) begin
                idx <= idx + 1'b1;
                case (state)
                    SQ_RESYNC: begin
                        if (idx == IW'(RESYNC_N - 1)) begin
                            idx   <= '0;
                            state <= SQ_IDLE;
                        end
                    end
                    SQ_ADDR: begin
                        sh_w <= sh_w >> 1;
                        if (idx == IW'(ADDR_W - 1)) begin
                            idx <= '0;
                            case (kind)
                                K_WR:    state <= SQ_WDATA;
                                K_RD:    state <= SQ_RDATA;
                                default: begin
                                    state  <= SQ_IDLE;
                                    done_q <= 1'b1;
                                end
                            endcase
                        end
                    end
                    SQ_WDATA: begin
                        sh_w <= sh_w >> 1;
                        if (idx == IW'(DATA_W - 1)) begin
                            idx    <= '0;
                            state  <= SQ_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                    SQ_RDATA: begin
                        sh_r <= {phy_rbit, sh_r[DATA_W-1:1]};
                        if (idx == IW'(DATA_W - 1)) begin
                            idx    <= '0;
                            state  <= SQ_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && !phy_bit_done) |=> busy); // R10
    AST_RESYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy && !done)); // R1

endmodule

// File: rtl/srtc_master.sv
module srtc_master
    import srtc_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RESYNC_N = 8,
    parameter int CMD_BASE = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rd_n,
    output logic              sd_o,
    output logic              sd_oe,
    input  logic              sd_i
);
    localparam int US_RAW = (CLK_HZ + 999_999) / 1_000_000;
    localparam int US_CYC = (US_RAW < 1) ? 1 : US_RAW;

    logic phy_start, phy_is_rd, phy_wbit;
    logic phy_ready, phy_bit_done, phy_rbit;

    srtc_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RESYNC_N(RESYNC_N),
        .CMD_BASE(CMD_BASE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .phy_ready   (phy_ready),
        .phy_bit_done(phy_bit_done),
        .phy_rbit    (phy_rbit),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .phy_start   (phy_start),
        .phy_is_rd   (phy_is_rd),
        .phy_wbit    (phy_wbit)
    );

    srtc_bit_phy #(
        .US_CYC(US_CYC)
    ) u_phy (
        .clk     (clk),
        .rst     (rst),
        .start   (phy_start),
        .is_rd   (phy_is_rd),
        .wbit    (phy_wbit),
        .sd_i    (sd_i),
        .ready   (phy_ready),
        .bit_done(phy_bit_done),
        .rbit    (phy_rbit),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .sd_o    (sd_o),
        .sd_oe   (sd_oe)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> (wr_n && rd_n)); // R11

endmodule

// File: tb/sim_srtc_master.sv
module sim_srtc_master;
    localparam int CLK_HZ   = 10_000_000;
    localparam int US       = CLK_HZ / 1_000_000;
    localparam int CMD_BASE = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [3:0] req_addr = 4'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       busy, done, cs_n, wr_n, rd_n, sd_o, sd_oe;
    logic [7:0] rdata;
    logic       sd_i = 1'b0;

    always #10 clk = ~clk;

    srtc_master #(.CLK_HZ(CLK_HZ), .CMD_BASE(CMD_BASE)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .sd_o(sd_o),
        .sd_oe(sd_oe), .sd_i(sd_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus observer and device model, sampled on the falling clock edge.
    logic        pw = 1'b1, pr = 1'b1, pc = 1'b1;
    int          wlow = 0, rlow = 0, chigh = 0;
    int          tot_w = 0, tot_r = 0;
    int          capn = 0, frn = 0;
    logic [15:0] capw = '0;
    logic [7:0]  dev_byte = '0;
    int          ridx = 0;
    bit          seen_cs = 0;

    always @(negedge clk) begin
        if (rst) begin
            pw = 1'b1; pr = 1'b1; pc = 1'b1;
            wlow = 0; rlow = 0; chigh = 0; seen_cs = 0;
        end else begin
            if (!wr_n) wlow++;
            if (!rd_n) rlow++;
            if (cs_n) chigh++;
            if (pw && !wr_n) begin
                chk(pc == 1'b0, "R7 cs low before wr", pc, 0);
                chk(sd_oe == 1'b1, "R7 line driven in write", sd_oe, 1);
                if (capn < 16) capw[capn] = sd_o;
                capn++;
                tot_w++;
            end
            if (!pw && wr_n) begin
                chk(wlow == US, "R7 wr low width", wlow, US);
                chk(cs_n == 1'b0, "R7 wr rises before cs", cs_n, 0);
                wlow = 0;
            end
            if (pr && !rd_n) begin
                chk(sd_oe == 1'b0, "R8 line released in read", sd_oe, 0);
                sd_i = dev_byte[ridx];
                ridx = (ridx + 1) % 8;
                frn++;
                tot_r++;
            end
            if (!pr && rd_n) begin
                chk(rlow == 2 * US, "R8 rd low width", rlow, 2 * US);
                rlow = 0;
            end
            if (pc && !cs_n) begin
                if (seen_cs) chk(chigh >= US, "R9 gap between bits", chigh, US);
                seen_cs = 1;
                chigh = 0;
            end
            pw = wr_n; pr = rd_n; pc = cs_n;
        end
    end

    // Scoreboard
    typedef struct {
        int          nw;
        logic [15:0] bits;
        int          nr;
        logic [7:0]  rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    bit   last_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (last_done) begin
                chk(done == 1'b0, "R10 done lasts one cycle", done, 0);
                chk(cs_n && wr_n && rd_n && !sd_oe, "R11 idle bus quiet",
                    {cs_n, wr_n, rd_n, sd_oe}, 4'b1110);
            end
            last_done = done;
            if (done) begin
                chk(busy == 1'b0, "R10 busy low at done", busy, 0);
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    bit   ok;
                    e = q.pop_front();
                    chk(capn == e.nw, {e.tag, " write strobe count"}, capn, e.nw);
                    ok = 1;
                    for (int i = 0; i < e.nw && i < 16; i++)
                        if (capw[i] !== e.bits[i]) ok = 0;
                    chk(ok, {e.tag, " bit order"}, int'(capw), int'(e.bits));
                    chk(frn == e.nr, {e.tag, " read strobe count"}, frn, e.nr);
                    if (e.nr > 0)
                        chk(rdata == e.rd, {e.tag, " read byte"}, rdata, e.rd);
                end
            end
        end
    end

    task automatic send(input logic [1:0] op, input logic [3:0] addr,
                        input logic [7:0] wd, input logic [7:0] dv, input string tag);
        exp_t e;
        bit   cmd;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd    = op[1] || (addr >= 4'(CMD_BASE));
        e.nw   = (cmd || op == 2'd1) ? 4 : 12;
        e.bits = {4'd0, wd, addr};
        e.nr   = (!cmd && op == 2'd1) ? 8 : 0;
        e.rd   = dv;
        e.tag  = tag;
        capn = 0; capw = '0; frn = 0; ridx = 0; dev_byte = dv;
        q.push_back(e);
        req_op = op; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R3 busy after accept", busy, 1);
    endtask

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_all();
        int wcount;
        repeat (4) @(negedge clk);
        chk(cs_n && wr_n && rd_n, "R1 strobes high in reset", {cs_n, wr_n, rd_n}, 3'b111);
        chk(sd_oe == 1'b0, "R1 line released in reset", sd_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after reset", busy, 1);
        while (busy) @(negedge clk);
        chk(tot_r == 8, "R2 resync read count", tot_r, 8);
        chk(tot_w == 0, "R2 no writes in resync", tot_w, 0);
        chk(cs_n && wr_n && rd_n, "R11 idle after resync", {cs_n, wr_n, rd_n}, 3'b111);

        send(2'd0, 4'd5,  8'hA5, 8'h00, "R3 R4 write");
        drain();
        send(2'd1, 4'd2,  8'h00, 8'h3C, "R5 read");
        drain();
        send(2'd1, 4'd9,  8'h00, 8'h01, "R5 read lsb only");
        drain();
        send(2'd1, 4'd0,  8'h00, 8'hFE, "R5 read msb side");
        drain();
        send(2'd2, 4'd3,  8'hFF, 8'h00, "R6 command opcode");
        drain();
        send(2'd0, 4'd12, 8'h5A, 8'h00, "R6 write at threshold");
        drain();
        send(2'd1, 4'd15, 8'h00, 8'hAA, "R6 read above threshold");
        drain();
        send(2'd0, 4'd11, 8'h80, 8'h00, "R6 R4 write below threshold");
        drain();

        // Request during a frame must be ignored.
        send(2'd0, 4'd6, 8'hC3, 8'h00, "R10 busy write");
        repeat (30) @(negedge clk);
        req_op = 2'd1; req_addr = 4'd1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        wcount = tot_w + tot_r;
        repeat (300) @(negedge clk);
        chk(tot_w + tot_r == wcount, "R10 ignored request made no frame", tot_w + tot_r, wcount);
        chk(busy == 1'b0, "R10 idle after ignored request", busy, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150_000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog R10 actual=%0d expected=%0d", 150_000, 0);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule